// File: doc/BRIEF.md
# I2C Control Register Unit

This block holds the byte-wide control register of a small I2C peripheral and carries out the side effects that hardware applies to it. A host writes and reads the register through a simple byte port. The unit hands the latched controls to the serial bus engine: enable, general-call enable, start request, acknowledge enable, stop request and interrupt enable. It clears the start bit when the engine reports that a start condition went out, and raises an interrupt pulse at that moment.

Turning the peripheral on is a two-step action. The first write with the enable bit set while the unit is off latches the enable bit alone. A second write is needed to load the other controls. While the unit is off, every control except the stop request is held at zero and the bus pins are released.

The start bit means different things by mode. In master mode it asks for a repeated start at once. In slave mode it asks for a start as soon as the bus is free. The unit also decides whether a received general-call address gets an acknowledge.

Top module: `i2c_ctrl_reg`

## Requirements
- R1: After reset the register reads 00h. Bits 7 and 6 always read 0, whatever value was written.
- R2: The field positions are: bit 5 enable, bit 4 general-call enable, bit 3 start, bit 2 acknowledge enable, bit 1 stop, bit 0 interrupt enable. `rd_data` shows the latched bits in the same cycle, and reading changes nothing.
- R3: While enable is 0, the general-call enable, start, acknowledge enable and interrupt enable bits read 0, and `bus_release` is 1. The stop bit keeps its value across a disable.
- R4: While the unit is disabled, a write with bit 5 = 1 sets only the enable bit. A write with bit 5 = 0 changes nothing.
- R5: While the unit is enabled, a write loads all six fields from the written value. If bit 5 of that write is 0, the unit is disabled and bits 4, 3, 2 and 0 clear, while stop takes the written bit 1.
- R6: A `start_sent` pulse while start is 1 clears start at the next clock edge. This clear wins over a write in the same cycle.
- R7: `irq` is high for exactly the one cycle after the edge that clears start through `start_sent`, and only if interrupt enable is 1. It stays low when interrupt enable is 0 or when start was already 0.
- R8: `start_req` = start AND (`is_master` OR `bus_free`). This requests a repeated start in master mode, and a start when the bus is free in slave mode.
- R9: `gc_ack` is high in the same cycle that `addr_valid` is 1, enable and general-call enable are both 1, and `rx_addr` = 00h. An address of 01h is never acknowledged.
- R10: A `stop_done` pulse clears the stop bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write value |
| rd_data | output | 8 | Current register value |
| start_sent | input | 1 | Engine strobe: start condition transmitted |
| stop_done | input | 1 | Engine strobe: stop condition transmitted |
| bus_free | input | 1 | Bus idle indication |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| addr_valid | input | 1 | Received address byte is valid |
| rx_addr | input | 8 | Received address byte |
| pe_o | output | 1 | Peripheral enable |
| ack_en_o | output | 1 | Data acknowledge enable |
| stop_o | output | 1 | Stop request |
| ite_o | output | 1 | Interrupt enable |
| start_req | output | 1 | Start request to the engine |
| irq | output | 1 | Interrupt pulse on start sent |
| gc_ack | output | 1 | Acknowledge the general-call address |
| bus_release | output | 1 | Release the bus pins (unit disabled) |

## Verification
Register writes, `start_sent` and `stop_done` take effect one clock edge later. The bench drives each of these on a falling edge and samples `rd_data` on the next falling edge. `irq` comes from a register loaded at the same edge that clears start, so it is checked on that same falling edge and again one cycle later, where it must be low. `start_req`, `gc_ack` and `bus_release` are combinational, so they are sampled a short delay after their inputs change, within the same cycle.

// File: rtl/i2c_ctrl_pkg.sv
// Package: field positions and the field record of the I2C control register.
// Assumes an 8-bit register where the top two bits are reserved.
package i2c_ctrl_pkg;
    localparam int unsigned CR_W    = 8;
    localparam int unsigned BIT_PE  = 5;
    localparam int unsigned BIT_GC  = 4;
    localparam int unsigned BIT_STA = 3;
    localparam int unsigned BIT_ACK = 2;
    localparam int unsigned BIT_STO = 1;
    localparam int unsigned BIT_ITE = 0;

    typedef struct packed {
        logic pe;
        logic gc_en;
        logic sta;
        logic ack;
        logic sto;
        logic ite;
    } cr_fields_t;
endpackage

// File: rtl/i2c_cr_store.sv
// Module: i2c_cr_store
// Holds the control fields, applies the two-step enable, the disable clear,
// and the hardware clears of start and stop. Assumes single-cycle strobes.
module i2c_cr_store
    import i2c_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W = CR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start_sent,
    input  logic              stop_done,
    output cr_fields_t        cr,
    output logic              sta_clr
);
    cr_fields_t cr_q;

    // Purpose: hardware clear of start when the engine reports it sent.
    always_comb sta_clr = start_sent && cr_q.sta;

    // Purpose: register update from host writes and hardware strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else begin
            if (wr_en) begin
                if (!cr_q.pe) begin
                    if (wr_data[BIT_PE]) cr_q.pe <= 1'b1;
                end else begin
                    cr_q.pe  <= wr_data[BIT_PE];
                    cr_q.sto <= wr_data[BIT_STO];
                    if (wr_data[BIT_PE]) begin
                        cr_q.gc_en <= wr_data[BIT_GC];
                        cr_q.sta   <= wr_data[BIT_STA];
                        cr_q.ack   <= wr_data[BIT_ACK];
                        cr_q.ite   <= wr_data[BIT_ITE];
                    end else begin
                        cr_q.gc_en <= 1'b0;
                        cr_q.sta   <= 1'b0;
                        cr_q.ack   <= 1'b0;
                        cr_q.ite   <= 1'b0;
                    end
                end
            end
            if (sta_clr)   cr_q.sta <= 1'b0;
            if (stop_done) cr_q.sto <= 1'b0;
        end
    end

    assign cr = cr_q;
endmodule

// File: rtl/i2c_start_irq.sv
// Module: i2c_start_irq
// Forms the mode-dependent start request and the one-cycle interrupt pulse
// registered on the edge that clears start. Assumes sta_clr lasts one cycle.
module i2c_start_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic sta,
    input  logic ite,
    input  logic sta_clr,
    input  logic is_master,
    input  logic bus_free,
    output logic start_req,
    output logic irq
);
    // Purpose: master asks at once, slave waits for an idle bus.
    always_comb start_req = sta && (is_master || bus_free);

    // Purpose: pulse the interrupt with the start clear when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= sta_clr && ite;
    end
endmodule

// File: rtl/i2c_gc_decode.sv
// Module: i2c_gc_decode
// Decides whether a received address is the general-call address to be
// acknowledged. Assumes rx_addr is stable while addr_valid is high.
module i2c_gc_decode #(
    parameter int unsigned        ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]  GC_ADDR = '0
) (
    input  logic              pe,
    input  logic              gc_en,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] rx_addr,
    output logic              gc_ack
);
    // Purpose: exact match on the general-call value only.
    always_comb gc_ack = pe && gc_en && addr_valid && (rx_addr == GC_ADDR);
endmodule

// File: rtl/i2c_ctrl_reg.sv
// Module: i2c_ctrl_reg (top)
// Control register unit of a small I2C peripheral: byte read/write port,
// control outputs to the bus engine, start handling, general-call acknowledge.
// Assumes engine strobes are synchronous to clk and one cycle long.
module i2c_ctrl_reg
    import i2c_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W = CR_W,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              start_sent,
    input  logic              stop_done,
    input  logic              bus_free,
    input  logic              is_master,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] rx_addr,
    output logic              pe_o,
    output logic              ack_en_o,
    output logic              stop_o,
    output logic              ite_o,
    output logic              start_req,
    output logic              irq,
    output logic              gc_ack,
    output logic              bus_release
);
    localparam int unsigned RSV_W = DATA_W - $bits(cr_fields_t);

    cr_fields_t cr;
    logic       sta_clr;

    i2c_cr_store #(.DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .start_sent(start_sent), .stop_done(stop_done),
        .cr(cr), .sta_clr(sta_clr)
    );

    i2c_start_irq u_start (
        .clk(clk), .rst_n(rst_n), .sta(cr.sta), .ite(cr.ite),
        .sta_clr(sta_clr), .is_master(is_master), .bus_free(bus_free),
        .start_req(start_req), .irq(irq)
    );

    i2c_gc_decode #(.ADDR_W(ADDR_W)) u_gc (
        .pe(cr.pe), .gc_en(cr.gc_en), .addr_valid(addr_valid),
        .rx_addr(rx_addr), .gc_ack(gc_ack)
    );

    // Purpose: read view with reserved bits forced low.
    always_comb rd_data = {{RSV_W{1'b0}}, cr};

    // Purpose: control outputs to the engine.
    always_comb begin
        pe_o        = cr.pe;
        ack_en_o    = cr.ack;
        stop_o      = cr.sto;
        ite_o       = cr.ite;
        bus_release = !cr.pe;
    end
endmodule

// File: rtl/i2c_ctrl_reg_chk.sv
// Module: i2c_ctrl_reg_chk
// Property checker bound to i2c_ctrl_reg; observes ports only.
module i2c_ctrl_reg_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              start_sent,
    input logic              stop_done,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] rx_addr,
    input logic              irq,
    input logic              gc_ack,
    input logic              bus_release
);
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:6] == '0);

    p_disabled_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[5] |-> (rd_data[4:2] == 3'b000 && !rd_data[0] && bus_release));

    p_first_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_data[5] && wr_data[5]) |=>
        (rd_data[5] && rd_data[4:2] == 3'b000 && !rd_data[0]));

    p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_sent && rd_data[3]) |=> !rd_data[3]);

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(start_sent) && $past(rd_data[3]) && $past(rd_data[0])));

    p_gc_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gc_ack |-> (addr_valid && rx_addr == '0 && rd_data[4] && rd_data[5]));

    p_stop_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_done && !wr_en) |=> !rd_data[1]);
endmodule

bind i2c_ctrl_reg i2c_ctrl_reg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .start_sent(start_sent), .stop_done(stop_done),
    .addr_valid(addr_valid), .rx_addr(rx_addr), .irq(irq),
    .gc_ack(gc_ack), .bus_release(bus_release)
);

// File: tb/i2c_ctrl_reg_bench.sv
// Directed bench for i2c_ctrl_reg: one task per scenario.
module i2c_ctrl_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       start_sent = 1'b0, stop_done = 1'b0;
    logic       bus_free = 1'b0, is_master = 1'b1;
    logic       addr_valid = 1'b0;
    logic [7:0] rx_addr = '0;
    logic       pe_o, ack_en_o, stop_o, ite_o, start_req, irq, gc_ack, bus_release;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    i2c_ctrl_reg u_i2c_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .start_sent(start_sent), .stop_done(stop_done),
        .bus_free(bus_free), .is_master(is_master), .addr_valid(addr_valid),
        .rx_addr(rx_addr), .pe_o(pe_o), .ack_en_o(ack_en_o), .stop_o(stop_o),
        .ite_o(ite_o), .start_req(start_req), .irq(irq), .gc_ack(gc_ack),
        .bus_release(bus_release)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One write, captured at the next rising edge; returns on the following falling edge.
    task automatic reg_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start_sent();
        start_sent = 1'b1;
        @(negedge clk);
        start_sent = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset value", rd_data, 8'h00);
        check("R3 bus released at reset", {7'b0, bus_release}, 8'h01);
        check("R7 irq low at reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_enable();
        reg_write(8'h3F);
        check("R4 first enable sets only PE", rd_data, 8'h20);
        check("R3 bus driven when enabled", {7'b0, bus_release}, 8'h00);
        reg_write(8'hFF);
        check("R1 R5 second write loads fields, reserved 0", rd_data, 8'h3F);
        check("R2 field outputs", {4'b0, pe_o, ack_en_o, stop_o, ite_o}, 8'h0F);
        check("R2 read has no side effect", rd_data, 8'h3F);
    endtask

    task automatic t_disable();
        reg_write(8'h02);
        check("R5 disable keeps written stop only", rd_data, 8'h02);
        check("R3 bus released when disabled", {7'b0, bus_release}, 8'h01);
        reg_write(8'h1D);
        check("R4 write with PE=0 while disabled ignored", rd_data, 8'h02);
        reg_write(8'h20);
        check("R3 stop survives re-enable", rd_data, 8'h22);
        stop_done = 1'b1;
        @(negedge clk);
        stop_done = 1'b0;
        check("R10 stop cleared by stop_done", rd_data, 8'h20);
    endtask

    task automatic t_start_master();
        is_master = 1'b1; bus_free = 1'b0;
        reg_write(8'h29);
        check("R8 master start request", {7'b0, start_req}, 8'h01);
        pulse_start_sent();
        check("R6 start cleared", rd_data, 8'h21);
        check("R7 irq pulse", {7'b0, irq}, 8'h01);
        check("R8 request drops", {7'b0, start_req}, 8'h00);
        @(negedge clk);
        check("R7 irq single cycle", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_start_slave();
        is_master = 1'b0; bus_free = 1'b0;
        reg_write(8'h28);
        check("R8 slave waits for free bus", {7'b0, start_req}, 8'h00);
        bus_free = 1'b1;
        #1;
        check("R8 slave request on free bus", {7'b0, start_req}, 8'h01);
        pulse_start_sent();
        check("R6 slave start cleared", rd_data, 8'h20);
        check("R7 no irq when ITE=0", {7'b0, irq}, 8'h00);
        bus_free = 1'b0; is_master = 1'b1;
    endtask

    task automatic t_no_start();
        reg_write(8'h21);
        pulse_start_sent();
        check("R7 no irq when start already 0", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_collision();
        reg_write(8'h29);
        wr_en = 1'b1; wr_data = 8'h29; start_sent = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; start_sent = 1'b0;
        check("R6 hardware clear wins over write", rd_data, 8'h21);
        check("R7 irq on collision clear", {7'b0, irq}, 8'h01);
        @(negedge clk);
    endtask

    task automatic t_gc();
        reg_write(8'h30);
        addr_valid = 1'b1; rx_addr = 8'h00;
        #1;
        check("R9 general call acked", {7'b0, gc_ack}, 8'h01);
        rx_addr = 8'h01;
        #1;
        check("R9 address 01h not acked", {7'b0, gc_ack}, 8'h00);
        rx_addr = 8'h00;
        addr_valid = 1'b0;
        #1;
        check("R9 no ack without valid", {7'b0, gc_ack}, 8'h00);
        @(negedge clk);
        reg_write(8'h20);
        addr_valid = 1'b1;
        #1;
        check("R9 no ack with ENGC=0", {7'b0, gc_ack}, 8'h00);
        addr_valid = 1'b0;
        @(negedge clk);
        reg_write(8'h30);
        reg_write(8'h00);
        addr_valid = 1'b1;
        #1;
        check("R3 R9 ENGC cleared on disable", {7'b0, gc_ack}, 8'h00);
        addr_valid = 1'b0;
        @(negedge clk);
        reg_write(8'h20);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_disable();
        t_start_master();
        t_start_slave();
        t_no_start();
        t_collision();
        t_gc();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule